// File: doc/BRIEF.md
# Interval Timer with Atomic Count Capture

This block is a down-counting interval timer that sits behind a narrow register bus whose data path is half as wide as the counter. Software builds the reload period from two half-width registers. It controls the timer through a control register that holds persistent mode bits and two self-clearing command bits, one to start the count and one to stop it. Each time the count passes through zero, the block raises a sticky timeout flag and reloads the period. The timer then either keeps counting or halts, according to the selected mode. An interrupt line follows the flag while the interrupt enable bit is set.

The count changes on every cycle, so reading its two halves one after the other could mix halves from two different values. To avoid this, a write of any value to the capture-low register copies the whole counter into a capture register in one edge. Software then reads the frozen value back as two halves in either order. The counter runs downward, so a free-running tick is the bitwise complement of the captured value.

Register word indices are 0 status, 1 control, 2 period low, 3 period high, 4 capture low, 5 capture high. Indices 6 and 7 are unmapped.

Top module: `interval_timer`

## Requirements
- R1: After reset, every register and the counter are zero, the timer is stopped, `rdata`, `tmo_o` and `irq_o` are 0.
- R2: Index 2 holds the low half and index 3 the high half of the period. A write to either one stops the timer and loads the counter with the period as it stands after that write. Both registers read back as written.
- R3: Control bit 0 is interrupt enable and bit 1 is continuous mode. Both are stored and read back at the same positions. Bit 2 is a start command and bit 3 a stop command; neither is stored and both read as 0. When both are set in one write, the stop command wins.
- R4: While running, the counter drops by one per cycle. In a cycle where it is running at zero, a timeout event occurs and the counter reloads the period. A period P therefore gives P+1 cycles between events.
- R5: After a timeout event the timer stays running if continuous mode is set and stops otherwise. A start or stop command written in the same cycle overrides this.
- R6: A write of any value to index 4 copies the counter value from before that edge into the capture register. Index 4 reads its low half and index 5 its high half. Both halves hold until the next capture, and writes to index 5 have no effect.
- R7: Status bit 0 is the sticky timeout flag and bit 1 reads 1 while the timer runs. A write of any value to index 0 clears the flag, but a timeout event in the same cycle keeps it set.
- R8: `tmo_o` equals the timeout flag, and `irq_o` is the flag ANDed with the interrupt enable.
- R9: A read presents its data on `rdata` one cycle after `rd_en`, using register values from before that edge. `rdata` holds between reads. Unused upper bits and indices 6 and 7 read as 0, and writes to indices 6 and 7 change nothing.
- R10: Writing 0 to status and then 0 to control leaves the timer stopped, the flag clear and `irq_o` low. A following stop-only write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (3) | Register word index |
| wdata | input | HALF_W (16) | Write data |
| rdata | output | HALF_W (16) | Registered read data |
| tmo_o | output | 1 | Sticky timeout flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situations to reach from the ports are the single cycles where a timeout event lands in the same edge as a status clear, a stop command or a capture write. A second hard case is a capture taken just as the low half of the count wraps below zero and borrows from the high half. The stimulus programs short periods and then sweeps the offset of the status, control and capture writes across a known expiry cycle. It also loads a period of 0x0001_0002 and captures on successive cycles around the borrow. A long pseudo-random run of mixed reads, writes and small periods then drives the remaining overlaps, and a behavioural model checks the result every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Register word indices; software depends on this order.
    typedef enum logic [2:0] {
        REG_STAT = 3'd0,
        REG_CTRL = 3'd1,
        REG_PLO  = 3'd2,
        REG_PHI  = 3'd3,
        REG_SLO  = 3'd4,
        REG_SHI  = 3'd5
    } reg_idx_e;

    localparam int IDX_W = 3;

    // Control register bit positions
    localparam int CTL_IE   = 0;
    localparam int CTL_CONT = 1;
    localparam int CTL_GO   = 2;
    localparam int CTL_HALT = 3;

    // Status register bit positions
    localparam int ST_TMO = 0;
    localparam int ST_RUN = 1;

    typedef struct packed {
        logic stat;
        logic ctrl;
        logic plo;
        logic phi;
        logic snap;
    } wr_strobe_t;

    typedef struct packed {
        logic ie;
        logic cont;
    } ctl_mode_t;

    typedef struct packed {
        logic go;
        logic halt;
    } ctl_cmd_t;

    typedef struct packed {
        logic running;
        logic tmo;
    } tmr_state_t;

    function automatic wr_strobe_t decode_write(
        input logic           we,
        input logic           in_map,
        input logic [IDX_W-1:0] idx
    );
        wr_strobe_t s;
        logic       hit;
        hit    = we && in_map;
        s.stat = hit && (idx == REG_STAT);
        s.ctrl = hit && (idx == REG_CTRL);
        s.plo  = hit && (idx == REG_PLO);
        s.phi  = hit && (idx == REG_PHI);
        s.snap = hit && (idx == REG_SLO);
        return s;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_strobe_t        wr,
    input  logic [HALF_W-1:0] wdata,
    output ctl_mode_t         mode,
    output ctl_cmd_t          cmd,
    output logic [HALF_W-1:0] per_lo,
    output logic [HALF_W-1:0] per_hi,
    output logic              load,
    output logic [CNT_W-1:0]  load_val
);
    // Persistent control mode bits and the two period halves
    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= '0;
            per_lo <= '0;
            per_hi <= '0;
        end else begin
            if (wr.ctrl) begin
                mode.ie   <= wdata[CTL_IE];
                mode.cont <= wdata[CTL_CONT];
            end
            if (wr.plo) per_lo <= wdata;
            if (wr.phi) per_hi <= wdata;
        end
    end

    // Command bits are pulses derived from the write itself
    always_comb begin
        cmd.go   = wr.ctrl && wdata[CTL_GO];
        cmd.halt = wr.ctrl && wdata[CTL_HALT];
    end

    // A period write loads the counter with the merged new period
    always_comb begin
        load     = wr.plo || wr.phi;
        load_val = wr.plo ? {per_hi, wdata} : {wdata, per_lo};
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    input  ctl_cmd_t         cmd,
    input  logic             cont,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_d;
    logic             run_d;

    assign expire = running && (cnt == '0);

    always_comb begin
        cnt_d = cnt;
        if (load) begin
            cnt_d = load_val;
        end else if (running) begin
            cnt_d = expire ? period : cnt - CNT_W'(1);
        end
    end

    // Priority: period load, stop, start, end-of-period mode
    always_comb begin
        run_d = running;
        if (load) begin
            run_d = 1'b0;
        end else if (cmd.halt) begin
            run_d = 1'b0;
        end else if (cmd.go) begin
            run_d = 1'b1;
        end else if (expire) begin
            run_d = cont;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else begin
            cnt     <= cnt_d;
            running <= run_d;
        end
    end

endmodule

// File: rtl/tmr_status.sv
module tmr_status (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic clear,
    output logic tmo
);
    // A timeout event outranks a software clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            tmo <= 1'b0;
        end else if (expire) begin
            tmo <= 1'b1;
        end else if (clear) begin
            tmo <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_snapshot.sv
module tmr_snapshot #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] snap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (capture) begin
            snap <= cnt;
        end
    end

endmodule

// File: rtl/tmr_readback.sv
module tmr_readback
    import tmr_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              in_map,
    input  logic [IDX_W-1:0]  idx,
    input  tmr_state_t        st,
    input  ctl_mode_t         mode,
    input  logic [HALF_W-1:0] per_lo,
    input  logic [HALF_W-1:0] per_hi,
    input  logic [CNT_W-1:0]  snap,
    output logic [HALF_W-1:0] rdata
);
    logic [HALF_W-1:0] sel;

    always_comb begin
        sel = '0;
        if (in_map) begin
            case (reg_idx_e'(idx))
                REG_STAT: begin
                    sel[ST_TMO] = st.tmo;
                    sel[ST_RUN] = st.running;
                end
                REG_CTRL: begin
                    sel[CTL_IE]   = mode.ie;
                    sel[CTL_CONT] = mode.cont;
                end
                REG_PLO:  sel = per_lo;
                REG_PHI:  sel = per_hi;
                REG_SLO:  sel = snap[HALF_W-1:0];
                REG_SHI:  sel = snap[CNT_W-1:HALF_W];
                default:  sel = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= sel;
        end
    end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int ADDR_W = 3,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] rdata,
    output logic              tmo_o,
    output logic              irq_o
);
    logic              in_map;
    logic [IDX_W-1:0]  idx;
    wr_strobe_t        wr;
    ctl_mode_t         mode;
    ctl_cmd_t          cmd;
    logic [HALF_W-1:0] per_lo;
    logic [HALF_W-1:0] per_hi;
    logic              load;
    logic [CNT_W-1:0]  load_val;
    logic [CNT_W-1:0]  cnt_q;
    logic              run_q;
    logic              expire;
    logic [CNT_W-1:0]  snap_q;
    tmr_state_t        st;
    logic              ctl_ie;
    logic              ctl_cont;

    // Indices beyond the register window are unmapped
    assign in_map = (addr >> IDX_W) == '0;
    assign idx    = addr[IDX_W-1:0];
    assign wr     = decode_write(wr_en, in_map, idx);

    tmr_regs #(.HALF_W(HALF_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .wdata    (wdata),
        .mode     (mode),
        .cmd      (cmd),
        .per_lo   (per_lo),
        .per_hi   (per_hi),
        .load     (load),
        .load_val (load_val)
    );

    assign ctl_ie   = mode.ie;
    assign ctl_cont = mode.cont;

    tmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .period   ({per_hi, per_lo}),
        .cmd      (cmd),
        .cont     (ctl_cont),
        .cnt      (cnt_q),
        .running  (run_q),
        .expire   (expire)
    );

    tmr_status u_status (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .clear  (wr.stat),
        .tmo    (tmo_o)
    );

    tmr_snapshot #(.CNT_W(CNT_W)) u_snap (
        .clk     (clk),
        .rst     (rst),
        .capture (wr.snap),
        .cnt     (cnt_q),
        .snap    (snap_q)
    );

    assign st.running = run_q;
    assign st.tmo     = tmo_o;

    tmr_readback #(.HALF_W(HALF_W)) u_read (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rd_en),
        .in_map (in_map),
        .idx    (idx),
        .st     (st),
        .mode   (mode),
        .per_lo (per_lo),
        .per_hi (per_hi),
        .snap   (snap_q),
        .rdata  (rdata)
    );

    assign irq_o = tmo_o && ctl_ie;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int HALF_W = 16,
    parameter int ADDR_W = 3,
    localparam int CNT_W = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [HALF_W-1:0] wdata,
    input logic [CNT_W-1:0]  cnt,
    input logic              running,
    input logic [CNT_W-1:0]  snap,
    input logic              cont,
    input logic              ie,
    input logic              tmo,
    input logic              irq
);
    logic w_stat, w_ctrl, w_per, w_snap, at_zero;

    assign w_stat  = wr_en && (addr == ADDR_W'(0));
    assign w_ctrl  = wr_en && (addr == ADDR_W'(1));
    assign w_per   = wr_en && ((addr == ADDR_W'(2)) || (addr == ADDR_W'(3)));
    assign w_snap  = wr_en && (addr == ADDR_W'(4));
    assign at_zero = running && (cnt == '0);

    // R2: a period write halts the timer
    a_r2_period_stops: assert property (@(posedge clk) disable iff (rst)
        w_per |=> !running);

    // R3: stop command wins over start
    a_r3_halt_wins: assert property (@(posedge clk) disable iff (rst)
        (w_ctrl && wdata[3]) |=> !running);

    // R4: running count steps down by one
    a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
        (running && cnt != '0 && !w_per) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R5: one-shot mode halts after the timeout event
    a_r5_oneshot_halts: assert property (@(posedge clk) disable iff (rst)
        (at_zero && !cont && !w_ctrl && !w_per) |=> (!running && tmo));

    // R6: capture takes the pre-edge count
    a_r6_capture: assert property (@(posedge clk) disable iff (rst)
        w_snap |=> (snap == $past(cnt)));

    // R7: timeout event sets the flag, clear works otherwise
    a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
        at_zero |=> tmo);
    a_r7_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (w_stat && !at_zero) |=> !tmo);

    // R8: interrupt only with flag and enable
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq |-> (tmo && ie));

endmodule

bind interval_timer tmr_checker #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .cnt     (cnt_q),
    .running (run_q),
    .snap    (snap_q),
    .cont    (ctl_cont),
    .ie      (ctl_ie),
    .tmo     (tmo_o),
    .irq     (irq_o)
);

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        tmo_o;
    logic        irq_o;

    always #2.5 clk = ~clk;

    interval_timer u_dut (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .tmo_o (tmo_o),
        .irq_o (irq_o)
    );

    // Behavioural reference state
    bit [31:0] m_cnt, m_snap;
    bit [15:0] m_plo, m_phi, m_rdata;
    bit        m_run, m_tmo, m_ie, m_cont;

    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string cur_req = "R1";

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_snap = 0; m_plo = 0; m_phi = 0; m_rdata = 0;
            m_run = 0; m_tmo = 0; m_ie = 0; m_cont = 0;
        end else begin
            automatic bit [31:0] c = m_cnt;
            automatic bit [31:0] per = {m_phi, m_plo};
            automatic bit        r = m_run;
            automatic bit        ev = m_run && (m_cnt == 0);
            automatic bit [15:0] rv = 16'h0;
            case (addr)
                3'd0: rv = {14'h0, m_run, m_tmo};
                3'd1: rv = {14'h0, m_cont, m_ie};
                3'd2: rv = m_plo;
                3'd3: rv = m_phi;
                3'd4: rv = m_snap[15:0];
                3'd5: rv = m_snap[31:16];
                default: rv = 16'h0;
            endcase
            if (rd_en) m_rdata = rv;
            // timer stepping
            if (m_run) m_cnt = ev ? per : c - 1;
            if (ev) m_run = m_cont;
            if (ev) m_tmo = 1;
            if (wr_en) begin
                case (addr)
                    3'd0: if (!ev) m_tmo = 0;
                    3'd1: begin
                        if (wdata[3]) m_run = 0;
                        else if (wdata[2]) m_run = 1;
                        m_ie = wdata[0];
                        m_cont = wdata[1];
                    end
                    3'd2: begin m_plo = wdata; m_cnt = {m_phi, wdata}; m_run = 0; end
                    3'd3: begin m_phi = wdata; m_cnt = {wdata, m_plo}; m_run = 0; end
                    3'd4: m_snap = c;
                    default: ;
                endcase
            end
            if (r && 0) m_run = m_run;
        end
    end

    task automatic check_outputs();
        n_vec++;
        if (rdata !== m_rdata) begin
            n_fail++;
            $display("FAIL %s rdata actual=%h expected=%h", cur_req, rdata, m_rdata);
        end
        if (tmo_o !== m_tmo) begin
            n_fail++;
            $display("FAIL %s tmo_o actual=%b expected=%b", cur_req, tmo_o, m_tmo);
        end
        if (irq_o !== (m_tmo && m_ie)) begin
            n_fail++;
            $display("FAIL %s irq_o actual=%b expected=%b", cur_req, irq_o, m_tmo && m_ie);
        end
    endtask

    task automatic step(bit we, bit re, logic [2:0] a, logic [15:0] d);
        wr_en = we; rd_en = re; addr = a; wdata = d;
        @(negedge clk);
        check_outputs();
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d); step(1, 0, a, d); endtask
    task automatic rd(logic [2:0] a);                 step(0, 1, a, 16'h0); endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 3'd0, 16'h0);
    endtask
    task automatic rd_all();
        for (int i = 0; i < 8; i++) rd(3'(i));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1"; check_outputs();
        rst = 1'b0;
        rd_all(); idle(1);

        // R10: quiet sequence then a lone stop
        cur_req = "R10";
        wr(3'd0, 16'h0); wr(3'd1, 16'h0); rd(3'd0); wr(3'd1, 16'h0008); rd(3'd0); rd(3'd1);

        // R2: period halves, load on write
        cur_req = "R2";
        wr(3'd2, 16'h0005); wr(3'd3, 16'h0000); rd(3'd2); rd(3'd3);
        cur_req = "R6"; wr(3'd4, 16'hBEEF); rd(3'd4); rd(3'd5);

        // R3: start+stop together, strobes read zero
        cur_req = "R3";
        wr(3'd1, 16'h000F); rd(3'd1); rd(3'd0); idle(3);

        // R4 / R5: one-shot with interrupt enable
        cur_req = "R4";
        wr(3'd1, 16'h0005);
        for (int i = 0; i < 4; i++) begin wr(3'd4, 16'h0); rd(3'd4); end
        cur_req = "R5"; idle(6); rd(3'd0); rd(3'd0);
        cur_req = "R8"; idle(2); wr(3'd1, 16'h0000); idle(1); wr(3'd1, 16'h0001); idle(1);
        cur_req = "R7"; wr(3'd0, 16'h1234); rd(3'd0);

        // R7 / R5: clear and command writes swept across the expiry cycle
        for (int off = 0; off < 8; off++) begin
            cur_req = "R7";
            wr(3'd2, 16'h0003); wr(3'd1, 16'h0007); idle(off);
            wr(3'd0, 16'h0); rd(3'd0);
            cur_req = "R5";
            wr(3'd2, 16'h0002); wr(3'd1, 16'h0005); idle(off);
            wr(3'd1, (off[0]) ? 16'h0008 : 16'h0006); rd(3'd0); idle(2);
        end

        // R6: capture across a borrow from the high half
        cur_req = "R6";
        for (int k = 0; k < 6; k++) begin
            wr(3'd2, 16'h0002); wr(3'd3, 16'h0001); wr(3'd1, 16'h0006);
            idle(k); wr(3'd4, 16'h0); idle(3); rd(3'd5); rd(3'd4);
        end
        wr(3'd5, 16'hAAAA); rd(3'd5); rd(3'd4);

        // R2: maximum period, free-running capture
        cur_req = "R2";
        wr(3'd2, 16'hFFFF); wr(3'd3, 16'hFFFF); wr(3'd1, 16'h0006); idle(20);
        cur_req = "R6"; wr(3'd4, 16'h0); rd(3'd4); rd(3'd5); rd(3'd2); rd(3'd3);

        // R9: unmapped indices, latency, hold, read with write
        cur_req = "R9";
        wr(3'd6, 16'hFFFF); wr(3'd7, 16'hFFFF); rd(3'd6); rd(3'd7); rd(3'd2); idle(3);
        step(1, 1, 3'd2, 16'h0042); rd(3'd2); idle(2);

        // Pseudo-random mix
        cur_req = "R4";
        begin
            automatic bit [15:0] lf = 16'hACE1;
            for (int i = 0; i < 4000; i++) begin
                automatic bit [2:0] a;
                automatic bit [15:0] d;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                a = lf[2:0];
                d = {lf[7:0], lf[15:8]};
                case (lf[5:3])
                    3'd0, 3'd1: step(0, 1, a, 16'h0);
                    3'd2: step(1, lf[6], 3'd1, {12'h0, d[3:0]});
                    3'd3: step(1, 0, lf[6] ? 3'd2 : 3'd3, lf[6] ? {13'h0, d[2:0]} : {15'h0, d[0] & lf[9]});
                    3'd4: step(1, lf[7], lf[6] ? 3'd0 : 3'd4, d);
                    3'd5: step(1, 0, lf[6] ? 3'd5 : 3'd6, d);
                    default: step(0, 0, a, 16'h0);
                endcase
            end
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule